// File: doc/BRIEF.md
# Mode-Split Execution Unit with Skip Generation

This block is the execution stage of a small 8-bit sequencer core. Each cycle it may accept one instruction, made of an 8-bit opcode and two operands. The opcode picks one of two modes. In compute mode the unit produces a data result: basic arithmetic and logic, modulo and shifts, a copy of operand A for a delay-counter load, or a byte to send to a serial transmitter. In compare mode no data is produced. The unit only raises a skip flag that tells the sequencer to take its branch.

The same opcode space also carries the side effects of the instruction. These are strobes for a return stack (push and pop), subroutine call and return, delay-counter load, and transmit request. Operand fetch, the stack memory and the serializer sit outside this block.

By default the outputs are registered. An instruction offered with `issue` high on one clock edge shows its result and strobes after that edge, and the strobes last for exactly one cycle. Setting the parameter `OUT_REG` to 0 gives a purely combinational variant.

Top module: `mode_alu`

## Requirements
- R1: While reset is held and after its release, `result` is 0 and every strobe (`skip`, `push_stb`, `pop_stb`, `func_skip`, `dly_load`, `tx_en`) is low until an instruction is issued.
- R2: Opcode bit 5 = 0 with bits 4:3 = 00 is the basic group. Bits 2:0 select the operation: 000 A+B, 001 A-B, 010 A&B, 011 A|B, 100 ~A (B ignored), 101 A^B, 110 A*B, 111 A/B. Add and subtract wrap modulo 256, multiply keeps the low 8 bits, and division is unsigned.
- R3: Divide (basic 111) and modulo (bits 4:3 = 10, bits 2:0 = 000) with B = 0 return 8'hFF and raise no strobe. With B nonzero, modulo returns A mod B, unsigned.
- R4: Bits 4:3 = 10 with bits 2:0 = 001 gives A shifted left by B, and 010 gives A shifted right (logical) by B. A shift amount of 8 or more gives 0.
- R5: Opcode bit 5 = 1 is compare mode, unsigned. Bits 2:0 select: 000 equal, 001 not equal, 010 A<B, 011 A<=B, 100 A>B, 101 A>=B. `skip` is 1 exactly when the condition holds, and `result` keeps its previous value.
- R6: Compare code 110 raises `skip` exactly when the input `dly_cnt` is nonzero. Operands A and B do not take part.
- R7: Bits 4:3 = 10 with bits 2:0 = 011 raises only `push_stb`. Code 100 raises only `pop_stb`. Neither changes `result`.
- R8: Special code 101 (call) raises `skip` and `push_stb`. Special code 111 (return) raises `skip`, `pop_stb` and `func_skip`. Neither changes `result`.
- R9: Bits 4:3 = 01 raises only `dly_load`, and `result` takes operand A.
- R10: Bits 4:3 = 11 raises only `tx_en`, and `result` takes operand A (the byte to send).
- R11: Opcode bits 7 and 6 (operand immediate flags) do not change the result or any strobe.
- R12: Special code 110 and compare code 111 raise no strobe and leave `result` unchanged.
- R13: Every strobe is a single-cycle pulse. In a cycle that follows an edge where `issue` was low, all strobes are low and `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation code |
| opnd_a | input | DATA_W | Operand A |
| opnd_b | input | DATA_W | Operand B |
| dly_cnt | input | DLY_W | Current delay counter value |
| result | output | DATA_W | Data result |
| skip | output | 1 | Branch/skip request to the sequencer |
| push_stb | output | 1 | Stack push strobe |
| pop_stb | output | 1 | Stack pop strobe |
| func_skip | output | 1 | Return-from-subroutine flag |
| dly_load | output | 1 | Delay counter load strobe |
| tx_en | output | 1 | Transmit request strobe |

## Verification
The arithmetic cases use operand pairs that cross the 8-bit boundary: a sum over 255, a negative difference, and products of 256 and 260. These show whether the unit wraps or keeps the low bits instead of saturating. The compare cases put equal, smaller and larger operand pairs under every relation, so that a swapped or off-by-one comparison is caught. Shifts are tried at amount 1, at amount 7, and at amounts of 8 and 200. Division and modulo by zero are checked against nonzero divisors. Each strobe-producing opcode is compared against the full strobe vector. The idle cycles that follow, together with the compare, stack and unused codes, confirm that the pulses last one cycle and that the result register holds its value.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;

   typedef enum logic [1:0] {
      GRP_BASIC   = 2'b00,
      GRP_DELAY   = 2'b01,
      GRP_SPECIAL = 2'b10,
      GRP_TX      = 2'b11
   } grp_e;

   // decoded control for one instruction
   typedef struct packed {
      logic wr;     // instruction writes the result register
      logic cmp;    // compare mode
      logic push;
      logic pop;
      logic call;
      logic ret;
      logic dly;
      logic tx;
   } ctl_t;

   // strobe bundle as seen at the block's edge
   typedef struct packed {
      logic skip;
      logic push;
      logic pop;
      logic fskip;
      logic dly;
      logic tx;
   } stb_t;

   localparam stb_t STB_IDLE = '0;

endpackage

// File: rtl/mode_alu_decode.sv
module mode_alu_decode
   import mode_alu_pkg::*;
(
   input  logic [5:0] op,
   output ctl_t       ctl
);
   grp_e       grp;
   logic [2:0] fn;

   assign grp = grp_e'(op[4:3]);
   assign fn  = op[2:0];

   always_comb begin
      ctl = '0;
      if (op[5]) begin
         ctl.cmp = 1'b1;
      end else begin
         unique case (grp)
            GRP_BASIC: ctl.wr = 1'b1;
            GRP_DELAY: begin
               ctl.wr  = 1'b1;
               ctl.dly = 1'b1;
            end
            GRP_SPECIAL: begin
               unique case (fn)
                  3'b000, 3'b001, 3'b010: ctl.wr = 1'b1;
                  3'b011: ctl.push = 1'b1;
                  3'b100: ctl.pop  = 1'b1;
                  3'b101: ctl.call = 1'b1;
                  3'b111: ctl.ret  = 1'b1;
                  default: ctl = '0;
               endcase
            end
            GRP_TX: begin
               ctl.wr = 1'b1;
               ctl.tx = 1'b1;
            end
            default: ctl = '0;
         endcase
      end
   end
endmodule

// File: rtl/mode_alu_compute.sv
module mode_alu_compute
   import mode_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        grp,
   input  logic [2:0]        fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] val
);
   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
   localparam int unsigned       SH_LIM   = DATA_W;

   logic [2*DATA_W-1:0] prod;
   logic [DATA_W-1:0]   quo, rem, shl, shr;
   logic                b_zero, sh_big;

   assign prod   = a * b;
   assign b_zero = (b == '0);
   assign quo    = b_zero ? ALL_ONES : a / b;
   assign rem    = b_zero ? ALL_ONES : a % b;
   assign sh_big = (32'(b) >= SH_LIM);
   assign shl    = sh_big ? '0 : a << b;
   assign shr    = sh_big ? '0 : a >> b;

   always_comb begin
      val = a;
      unique case (grp_e'(grp))
         GRP_BASIC: begin
            unique case (fn)
               3'b000: val = a + b;
               3'b001: val = a - b;
               3'b010: val = a & b;
               3'b011: val = a | b;
               3'b100: val = ~a;
               3'b101: val = a ^ b;
               3'b110: val = prod[DATA_W-1:0];
               default: val = quo;
            endcase
         end
         GRP_SPECIAL: begin
            unique case (fn)
               3'b000:  val = rem;
               3'b001:  val = shl;
               3'b010:  val = shr;
               default: val = a;
            endcase
         end
         default: val = a;   // delay load and transmit pass operand A
      endcase
   end
endmodule

// File: rtl/mode_alu_compare.sv
module mode_alu_compare #(
   parameter int DATA_W = 8,
   parameter int DLY_W  = 24
) (
   input  logic [2:0]        fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DLY_W-1:0]  dly_cnt,
   output logic              hold
);
   always_comb begin
      unique case (fn)
         3'b000:  hold = (a == b);
         3'b001:  hold = (a != b);
         3'b010:  hold = (a <  b);
         3'b011:  hold = (a <= b);
         3'b100:  hold = (a >  b);
         3'b101:  hold = (a >= b);
         3'b110:  hold = (dly_cnt != '0);
         default: hold = 1'b0;
      endcase
   end
endmodule

// File: rtl/mode_alu.sv
module mode_alu
   import mode_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DLY_W   = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DLY_W-1:0]  dly_cnt,
   output logic [DATA_W-1:0] result,
   output logic              skip,
   output logic              push_stb,
   output logic              pop_stb,
   output logic              func_skip,
   output logic              dly_load,
   output logic              tx_en
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_dw
      $error("mode_alu: DATA_W must lie in 2..16");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("mode_alu: DLY_W must be at least 1");
   end

   // immediate flags are consumed by operand fetch, not here
   logic imm_unused;
   assign imm_unused = ^opcode[7:6];

   ctl_t              ctl;
   logic [DATA_W-1:0] val;
   logic              cond;
   stb_t              nxt, cur;

   mode_alu_decode u_dec (
      .op  (opcode[5:0]),
      .ctl (ctl)
   );

   mode_alu_compute #(.DATA_W(DATA_W)) u_cmp_path (
      .grp (opcode[4:3]),
      .fn  (opcode[2:0]),
      .a   (opnd_a),
      .b   (opnd_b),
      .val (val)
   );

   mode_alu_compare #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_rel (
      .fn      (opcode[2:0]),
      .a       (opnd_a),
      .b       (opnd_b),
      .dly_cnt (dly_cnt),
      .hold    (cond)
   );

   always_comb begin
      nxt       = STB_IDLE;
      nxt.skip  = (ctl.cmp & cond) | ctl.call | ctl.ret;
      nxt.push  = ctl.push | ctl.call;
      nxt.pop   = ctl.pop | ctl.ret;
      nxt.fskip = ctl.ret;
      nxt.dly   = ctl.dly;
      nxt.tx    = ctl.tx;
   end

   if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_q;
      stb_t              stb_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q <= '0;
            stb_q <= STB_IDLE;
         end else begin
            stb_q <= issue ? nxt : STB_IDLE;
            if (issue && ctl.wr) res_q <= val;
         end
      end

      assign result = res_q;
      assign cur    = stb_q;

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !issue |=> (stb_q == STB_IDLE)) else $error("strobe after idle"); // R13
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !issue |=> $stable(res_q)) else $error("result moved while idle"); // R13
      AST_CMP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         (issue && opcode[5]) |=> $stable(res_q)) else $error("compare wrote result"); // R5
   end else begin : g_comb
      assign result = val;
      assign cur    = issue ? nxt : STB_IDLE;
   end

   assign skip      = cur.skip;
   assign push_stb  = cur.push;
   assign pop_stb   = cur.pop;
   assign func_skip = cur.fskip;
   assign dly_load  = cur.dly;
   assign tx_en     = cur.tx;

   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_stb && pop_stb)) else $error("push and pop together"); // R7
   AST_FSKIP_IS_RET: assert property (@(posedge clk) disable iff (!rst_n)
      func_skip |-> (skip && pop_stb && !push_stb)) else $error("bad return strobes"); // R8
   AST_SIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_stb, pop_stb, dly_load, tx_en})) else $error("side effects overlap"); // R10
   AST_DLY_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_load || tx_en) |-> !skip) else $error("skip with load or send"); // R9
endmodule

// File: tb/mode_alu_tb.sv
module mode_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [7:0]  opcode = '0;
   logic [7:0]  opnd_a = '0;
   logic [7:0]  opnd_b = '0;
   logic [23:0] dly_cnt = '0;
   logic [7:0]  result;
   logic        skip, push_stb, pop_stb, func_skip, dly_load, tx_en;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   mode_alu dut_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .dly_cnt(dly_cnt),
      .result(result), .skip(skip), .push_stb(push_stb), .pop_stb(pop_stb),
      .func_skip(func_skip), .dly_load(dly_load), .tx_en(tx_en)
   );

   // strobe order {skip, push, pop, func_skip, dly_load, tx_en}
   function automatic logic [5:0] stb();
      return {skip, push_stb, pop_stb, func_skip, dly_load, tx_en};
   endfunction

   task automatic chk(input string tag, input logic [7:0] res_exp, input logic [5:0] stb_exp);
      total++;
      if (result !== res_exp || stb() !== stb_exp) begin
         bad++;
         $display("FAIL %s: result=%h stb=%b expected result=%h stb=%b",
                  tag, result, stb(), res_exp, stb_exp);
      end
   endtask

   // issue one instruction, sample one edge later, then go idle
   task automatic run(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [23:0] d);
      @(negedge clk);
      opcode = op; opnd_a = a; opnd_b = b; dly_cnt = d; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset", 8'h00, 6'b0);
   endtask

   task automatic t_basic();
      run(8'h00, 8'd200, 8'd100, 0); chk("R2 add wrap", 8'd44, 6'b0);
      run(8'h01, 8'd5, 8'd10, 0);    chk("R2 sub wrap", 8'd251, 6'b0);
      run(8'h02, 8'hF0, 8'h3C, 0);   chk("R2 and", 8'h30, 6'b0);
      run(8'h03, 8'hF0, 8'h0F, 0);   chk("R2 or", 8'hFF, 6'b0);
      run(8'h04, 8'h5A, 8'hFF, 0);   chk("R2 not", 8'hA5, 6'b0);
      run(8'h05, 8'hFF, 8'h0F, 0);   chk("R2 xor", 8'hF0, 6'b0);
      run(8'h06, 8'd20, 8'd13, 0);   chk("R2 mul 260", 8'd4, 6'b0);
      run(8'h06, 8'd16, 8'd16, 0);   chk("R2 mul 256", 8'd0, 6'b0);
      run(8'h07, 8'd100, 8'd7, 0);   chk("R2 div", 8'd14, 6'b0);
   endtask

   task automatic t_divzero();
      run(8'h07, 8'd7, 8'd0, 0);     chk("R3 div by zero", 8'hFF, 6'b0);
      run(8'h10, 8'd100, 8'd7, 0);   chk("R3 mod", 8'd2, 6'b0);
      run(8'h10, 8'd9, 8'd0, 0);     chk("R3 mod by zero", 8'hFF, 6'b0);
   endtask

   task automatic t_shift();
      run(8'h11, 8'd3, 8'd2, 0);     chk("R4 shl", 8'd12, 6'b0);
      run(8'h11, 8'h81, 8'd1, 0);    chk("R4 shl drop msb", 8'h02, 6'b0);
      run(8'h11, 8'hFF, 8'd8, 0);    chk("R4 shl by 8", 8'h00, 6'b0);
      run(8'h12, 8'h80, 8'd7, 0);    chk("R4 shr 7", 8'h01, 6'b0);
      run(8'h12, 8'hFF, 8'd200, 0);  chk("R4 shr by 200", 8'h00, 6'b0);
   endtask

   task automatic t_compare();
      run(8'h00, 8'd50, 8'd5, 0);    chk("R5 seed", 8'd55, 6'b0);
      run(8'h20, 8'd5, 8'd5, 0);     chk("R5 eq true", 8'd55, 6'b100000);
      run(8'h20, 8'd5, 8'd6, 0);     chk("R5 eq false", 8'd55, 6'b0);
      run(8'h21, 8'd5, 8'd6, 0);     chk("R5 ne true", 8'd55, 6'b100000);
      run(8'h22, 8'd3, 8'd4, 0);     chk("R5 lt true", 8'd55, 6'b100000);
      run(8'h22, 8'd4, 8'd4, 0);     chk("R5 lt equal", 8'd55, 6'b0);
      run(8'h23, 8'd4, 8'd4, 0);     chk("R5 le equal", 8'd55, 6'b100000);
      run(8'h23, 8'd5, 8'd4, 0);     chk("R5 le false", 8'd55, 6'b0);
      run(8'h24, 8'd200, 8'd100, 0); chk("R5 gt unsigned", 8'd55, 6'b100000);
      run(8'h24, 8'd4, 8'd4, 0);     chk("R5 gt equal", 8'd55, 6'b0);
      run(8'h25, 8'd4, 8'd4, 0);     chk("R5 ge equal", 8'd55, 6'b100000);
      run(8'h25, 8'd3, 8'd4, 0);     chk("R5 ge false", 8'd55, 6'b0);
   endtask

   task automatic t_delay_cmp();
      run(8'h26, 8'd1, 8'd1, 24'd0);       chk("R6 delay zero", 8'd55, 6'b0);
      run(8'h26, 8'd0, 8'd9, 24'h100000);  chk("R6 delay nonzero", 8'd55, 6'b100000);
   endtask

   task automatic t_stack();
      run(8'h13, 8'd1, 8'd2, 0);     chk("R7 push", 8'd55, 6'b010000);
      run(8'h14, 8'd1, 8'd2, 0);     chk("R7 pop", 8'd55, 6'b001000);
      run(8'h15, 8'd1, 8'd2, 0);     chk("R8 call", 8'd55, 6'b110000);
      run(8'h17, 8'd1, 8'd2, 0);     chk("R8 return", 8'd55, 6'b101100);
   endtask

   task automatic t_side();
      run(8'h08, 8'h3C, 8'h11, 0);   chk("R9 delay load", 8'h3C, 6'b000010);
      run(8'h18, 8'h41, 8'h22, 0);   chk("R10 transmit", 8'h41, 6'b000001);
   endtask

   task automatic t_imm();
      run(8'hC0, 8'd200, 8'd100, 0); chk("R11 flags on add", 8'd44, 6'b0);
      run(8'hE2, 8'd3, 8'd4, 0);     chk("R11 flags on lt", 8'd44, 6'b100000);
      run(8'h95, 8'd3, 8'd4, 0);     chk("R11 flags on call", 8'd44, 6'b110000);
   endtask

   task automatic t_unused();
      run(8'h16, 8'd9, 8'd9, 0);     chk("R12 special 110", 8'd44, 6'b0);
      run(8'h27, 8'd9, 8'd9, 24'd5); chk("R12 compare 111", 8'd44, 6'b0);
   endtask

   task automatic t_pulse();
      run(8'h17, 8'd0, 8'd0, 0);     chk("R13 return pulse", 8'd44, 6'b101100);
      opcode = 8'h00; opnd_a = 8'd1; opnd_b = 8'd1;
      @(negedge clk);                chk("R13 idle after return", 8'd44, 6'b0);
      run(8'h18, 8'h77, 8'd0, 0);    chk("R13 send pulse", 8'h77, 6'b000001);
      @(negedge clk);                chk("R13 idle after send", 8'h77, 6'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_divzero();
      t_shift();
      t_compare();
      t_delay_cmp();
      t_stack();
      t_side();
      t_imm();
      t_unused();
      t_pulse();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule